// File: doc/BRIEF.md
# Daisy-Chain SPI Slave Front End

This block receives serial data as an SPI slave inside the system clock domain. The serial clock, the data input and the active-low select come in asynchronously. Each one passes through a synchroniser, and clock edges are found by comparing successive synchronised samples. The clock polarity and clock phase are static configuration inputs, so all four bus modes are handled by the same logic. Each complete byte is kept in a small frame buffer and is handed to the parallel side only after the frame has been judged valid.

The serial output carries, during every group of eight clocks, the byte that arrived during the previous group. This lets any number of these slaves be wired output-to-input and share one select. The whole chain then behaves as one long shift register. A frame whose clock count is not a whole number of bytes is dropped completely. Outside a selected frame the serial output is released, with its enable held low.

Top module: `spi_chain_slave`

## Requirements
- R1: During reset and directly after it, `miso_oe` is 0, `rx_strobe` is 0 and `rx_byte` is 0x00.
- R2: `miso_oe` is 1 from three clocks after `sel_n_in` falls until `sel_n_in` rises. It is 0 from three clocks after `sel_n_in` rises.
- R3: Bus mode m sets `cfg_cpol` = m[1] and `cfg_cpha` = m[0]. With both at 0, data is sampled on the rising serial clock edge and the output changes on the falling edge. Setting `cfg_cpha` to 1 swaps these two edges. Setting `cfg_cpol` to 1 makes the idle level 1 and inverts both edges.
- R4: Each received byte is assembled most significant bit first. The first sampled bit of a group becomes bit 7.
- R5: During group k of a frame (k from 0), `miso_out` shifts out the byte received in group k-1, most significant bit first. In group 0 it shifts out 0x00. Each bit is stable at its sampling edge.
- R6: With `cfg_cpha` = 0, the first output bit of a frame (0) is on `miso_out` once select is seen low, before any serial clock edge.
- R7: A frame whose serial clock pulse count is not a multiple of 8 produces no `rx_strobe` at all.
- R8: After select rises on a valid frame, its stored bytes appear on `rx_byte` in arrival order. Each byte comes with a one-clock `rx_strobe`, the strobes fall on consecutive clocks, and no strobe occurs while selected. `rx_byte` changes only in a strobe cycle. A frame with no clocks delivers nothing.
- R9: At most DEPTH bytes of one frame are delivered, namely the first DEPTH. Later bytes are still echoed on `miso_out`.
- R10: Serial clock and data activity while select is high changes no output and does not disturb the next frame.
- R11: One select assertion may carry several bytes, and all of them are delivered, up to DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Clock idle level (static) |
| cfg_cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge (static) |
| sclk_in | input | 1 | Serial clock, asynchronous |
| mosi_in | input | 1 | Serial data into the slave, asynchronous |
| sel_n_in | input | 1 | Active-low select, asynchronous |
| miso_out | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Output enable for `miso_out`; 0 means high impedance |
| rx_byte | output | 8 | Last delivered byte |
| rx_strobe | output | 1 | One-clock pulse for each delivered byte |

## Verification
The assertions take for granted that select stays high for the whole release burst, which lasts at most DEPTH clocks. They also take for granted that every serial clock half period lasts at least two system clocks. This keeps frames and releases from overlapping, and it keeps the synchronised edges one clock apart. The stimulus holds each half period for six system clocks, waits eight clocks after select falls before the first edge, and keeps select high for over twenty clocks between frames.

// File: rtl/spi_chain_pkg.sv
// Shared constants and types for the daisy-chain SPI slave.
package spi_chain_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module spi_in_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
// Serial bit engine: detects sample and shift edges on the synchronised clock
// for the configured polarity/phase, assembles bytes MSB first and shifts out
// the byte of the previous group. Assumes synchronised inputs, and serial
// clock half periods of at least two system clocks.
module spi_bit_engine
    import spi_chain_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cpol,
    input  logic  cpha,
    input  logic  sclk_s,
    input  logic  mosi_s,
    input  logic  seln_s,
    output logic  miso_bit,
    output logic  byte_done,
    output byte_t byte_val,
    output logic  frame_start,
    output logic  frame_end,
    output logic  frame_ok
);
    logic             sclk_d, seln_d;
    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sr, tx_sr, tx_next;
    logic             rise, fall, lead, trail, samp, shft, active, last_bit;

    assign rise        = sclk_s & ~sclk_d;
    assign fall        = ~sclk_s & sclk_d;
    assign lead        = cpol ? fall : rise;
    assign trail       = cpol ? rise : fall;
    assign samp        = cpha ? trail : lead;
    assign shft        = cpha ? lead : trail;
    assign frame_start = seln_d & ~seln_s;
    assign frame_end   = seln_s & ~seln_d;
    assign active      = ~seln_s & ~frame_start;
    assign last_bit    = bit_cnt == CNT_W'(BYTE_W - 1);
    assign frame_ok    = bit_cnt == '0;

    // Delay the synchronised clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            seln_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            seln_d <= seln_s;
        end
    end

    // Receive and transmit shifting, cleared when a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            tx_next <= '0;
        end else if (active) begin
            if (samp) begin
                rx_sr   <= byte_val;
                bit_cnt <= bit_cnt + CNT_W'(1);
                if (last_bit) begin
                    tx_next <= byte_val;
                end
            end
            if (shft) begin
                if (bit_cnt == '0) begin
                    tx_sr <= tx_next;
                end else begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign byte_val  = {rx_sr[BYTE_W-2:0], mosi_s};
    assign byte_done = active & samp & last_bit;
    assign miso_bit  = tx_sr[BYTE_W-1];
endmodule

// File: rtl/spi_hold_buf.sv
// Frame buffer: stores up to DEPTH bytes of the current frame and, on a
// release request, emits them in order with one strobe per clock.
// Assumes no new frame starts while a release is in progress.
module spi_hold_buf
    import spi_chain_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  clear,
    input  logic  release_req,
    output byte_t rx_byte,
    output logic  rx_strobe
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    byte_t         mem [DEPTH];
    logic [PW-1:0] wr_cnt, rd_idx;
    logic          rel_on, room;

    assign room = wr_cnt < PW'(DEPTH);

    // Write accepted bytes into the buffer.
    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            mem[wr_cnt[IW-1:0]] <= wr_data;
        end
    end

    // Track fill level and run the release burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt    <= '0;
            rd_idx    <= '0;
            rel_on    <= 1'b0;
            rx_strobe <= 1'b0;
            rx_byte   <= '0;
        end else begin
            rx_strobe <= 1'b0;
            if (clear) begin
                wr_cnt <= '0;
            end else if (wr_en && room) begin
                wr_cnt <= wr_cnt + PW'(1);
            end
            if (release_req) begin
                rel_on <= wr_cnt != '0;
                rd_idx <= '0;
            end else if (rel_on) begin
                rx_strobe <= 1'b1;
                rx_byte   <= mem[rd_idx[IW-1:0]];
                rd_idx    <= rd_idx + PW'(1);
                if (rd_idx + PW'(1) == wr_cnt) begin
                    rel_on <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spi_chain_slave.sv
// Daisy-chain SPI slave front end in the system clock domain. Synchronises
// the serial inputs, runs the bit engine and releases the bytes of a frame
// only when the frame length is a whole number of bytes.
// Assumes the serial clock is at most a quarter of the system clock rate.
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              sel_n_in,
    output logic              miso_out,
    output logic              miso_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_strobe
);
    logic  sclk_s, mosi_s, seln_s;
    logic  byte_done, frame_start, frame_end, frame_ok;
    byte_t byte_val;

    spi_in_sync #(
        .W(3),
        .STAGES(SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, mosi_in, sel_n_in}),
        .q     ({sclk_s, mosi_s, seln_s})
    );

    spi_bit_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpol        (cfg_cpol),
        .cpha        (cfg_cpha),
        .sclk_s      (sclk_s),
        .mosi_s      (mosi_s),
        .seln_s      (seln_s),
        .miso_bit    (miso_out),
        .byte_done   (byte_done),
        .byte_val    (byte_val),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .frame_ok    (frame_ok)
    );

    spi_hold_buf #(
        .DEPTH(DEPTH)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (byte_done),
        .wr_data     (byte_val),
        .clear       (frame_start),
        .release_req (frame_end & frame_ok),
        .rx_byte     (rx_byte),
        .rx_strobe   (rx_strobe)
    );

    assign miso_oe = ~seln_s;
endmodule

// File: rtl/spi_chain_slave_chk.sv
// Checker for the daisy-chain SPI slave, bound to the top module. Assumes
// select stays high through each release burst.
module spi_chain_slave_chk #(
    parameter int DEPTH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_n_in,
    input logic       miso_oe,
    input logic       rx_strobe,
    input logic [7:0] rx_byte
);
    logic [2:0]  hi_cnt, lo_cnt;
    logic [15:0] run_cnt;
    logic        past_ok;

    // Count clocks that select has spent high or low, and strobe run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            run_cnt <= '0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            hi_cnt  <= sel_n_in ? ((hi_cnt == 3'd7) ? hi_cnt : hi_cnt + 3'd1) : 3'd0;
            lo_cnt  <= !sel_n_in ? ((lo_cnt == 3'd7) ? lo_cnt : lo_cnt + 3'd1) : 3'd0;
            run_cnt <= rx_strobe ? run_cnt + 16'd1 : 16'd0;
        end
    end

    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt >= 3'd3 |-> !miso_oe);

    // R2
    oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt >= 3'd3 |-> miso_oe);

    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> hi_cnt >= 3'd2);

    // R8
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !rx_strobe) |-> $stable(rx_byte));

    // R9
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> run_cnt < 16'(DEPTH));
endmodule

bind spi_chain_slave spi_chain_slave_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_in  (sel_n_in),
    .miso_oe   (miso_oe),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte)
);

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int DEPTH = 4;

    typedef struct packed {
        logic [1:0]  mode;
        int          nb;
        int          ex;
        logic [63:0] data;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{2'd0, 1, 0, 64'hA500_0000_0000_0000},
        '{2'd1, 2, 0, 64'h3C81_0000_0000_0000},
        '{2'd2, 3, 0, 64'h01FE_5500_0000_0000},
        '{2'd3, 4, 0, 64'hDEAD_BEEF_0000_0000},
        '{2'd0, 2, 3, 64'h1234_E000_0000_0000},
        '{2'd3, 1, 7, 64'h77FF_0000_0000_0000},
        '{2'd1, 6, 0, 64'h1122_3344_5566_0000},
        '{2'd2, 0, 5, 64'hF800_0000_0000_0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, sel_n = 1'b1;
    logic miso_out, miso_oe, rx_strobe;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0, got_n = 0, cyc = 0;
    logic [7:0] got [16];
    int got_cyc [16];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_chain_slave #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .sclk_in(sclk), .mosi_in(mosi), .sel_n_in(sel_n),
        .miso_out(miso_out), .miso_oe(miso_oe),
        .rx_byte(rx_byte), .rx_strobe(rx_strobe)
    );

    // Record delivered bytes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_strobe && got_n < 16) begin
            got[got_n] = rx_byte;
            got_cyc[got_n] = cyc;
            got_n = got_n + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [1:0] mode, input int nb, input int ex,
                             input logic [63:0] data, output logic [63:0] cap);
        int nbits;
        nbits = nb * 8 + ex;
        cap = '0;
        cfg_cpol = mode[1];
        cfg_cpha = mode[0];
        sclk = mode[1];
        mosi = 1'b0;
        repeat (8) @(negedge clk);
        got_n = 0;
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R2", miso_oe, 1);
        for (int k = 0; k < nbits; k++) begin
            logic b;
            b = (k < 64) ? data[63-k] : 1'b0;
            if (!mode[0]) begin
                mosi = b;
                repeat (HALF) @(negedge clk);
                if (k < 64) cap[63-k] = miso_out;
                sclk = ~mode[1];
                repeat (HALF) @(negedge clk);
                sclk = mode[1];
            end else begin
                sclk = ~mode[1];
                mosi = b;
                repeat (HALF) @(negedge clk);
                if (k < 64) cap[63-k] = miso_out;
                sclk = mode[1];
                repeat (HALF) @(negedge clk);
            end
        end
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (24) @(negedge clk);
        check("R2", miso_oe, 0);
    endtask

    task automatic do_vec(input vec_t v);
        logic [63:0] cap;
        int exp_n;
        string ctag;
        run_frame(v.mode, v.nb, v.ex, v.data, cap);
        exp_n = (v.ex != 0) ? 0 : ((v.nb > DEPTH) ? DEPTH : v.nb);
        ctag = (v.ex != 0) ? "R7" : ((v.nb > DEPTH) ? "R9" : ((v.nb > 1) ? "R11" : "R8"));
        check(ctag, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check("R3 R4", got[i], v.data[63-8*i -: 8]);
            check("R8", got_cyc[i] - got_cyc[0], i);
        end
        for (int j = 0; j < v.nb && j < 8; j++) begin
            logic [7:0] e;
            e = (j == 0) ? 8'h00 : v.data[63-8*(j-1) -: 8];
            check("R5", cap[63-8*j -: 8], e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8: watchdog expired actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t dv;
        repeat (4) @(negedge clk);
        // R1: values held in reset
        check("R1", miso_oe, 0);
        check("R1", rx_strobe, 0);
        check("R1", rx_byte, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", miso_oe, 0);
        check("R1", rx_byte, 0);

        for (int n = 0; n < 8; n++) begin
            do_vec(VECS[n]);
        end

        // R6: leave a byte with MSB set loaded, then reselect in mode 0
        dv = '{2'd0, 1, 0, 64'h8000_0000_0000_0000};
        do_vec(dv);
        got_n = 0;
        sel_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R6", miso_out, 0);
        sel_n = 1'b1;
        repeat (24) @(negedge clk);
        check("R8", got_n, 0);

        // R10: clock and data toggling while deselected
        got_n = 0;
        for (int t = 0; t < 16; t++) begin
            sclk = ~sclk;
            mosi = t[1];
            repeat (HALF) @(negedge clk);
            check("R10", miso_oe, 0);
        end
        repeat (8) @(negedge clk);
        check("R10", got_n, 0);
        run_frame(2'd0, 1, 0, 64'h5A00_0000_0000_0000, dv.data);
        check("R10", got_n, 1);
        check("R10", got[0], 8'h5A);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule